// File: doc/BRIEF.md
# High-Bandwidth Isochronous Microframe Checker

This block watches one high-bandwidth isochronous endpoint that moves one, two or three transactions in every microframe. It follows the data PID of each transaction. For an IN endpoint it produces the PID to send next. For an OUT endpoint it records the PID last received and checks it against the order that high-bandwidth sequencing permits. At each microframe boundary it compares the banks the CPU handed over, and the transactions that completed, against the configured count. A shortfall raises sticky event flags and a one-cycle flush request that empties the banks.

Token decoding and bank storage sit outside the block. Neighbouring logic gives it a microframe-start pulse and per-transaction pulses. It also receives the PID of each OUT packet and a pulse each time software releases a bank. A transaction-error flag for OUT stays tied to the banks of the bad microframe. It drops only once software has released every one of them, along with any older banks still queued ahead of them.

Top module: `hbiso_ufrm_chk`

## Requirements
- R1: After reset all flags and pulses are low and `pid_seq` reads 1 (DATA1), so DATA0 comes next. PID codes are 0 = DATA0, 1 = DATA1, 2 = DATA2, 3 = MDATA.
- R2: For IN (`is_in` = 1), `ufrm_start` loads `pid_seq` with DATA2, DATA1 or DATA0 for N = 3, 2 or 1. Each `trans_done` steps it DATA2→DATA1→DATA0, and it stays at DATA0 after that. `n_trans` values 0 and 1 both mean N = 1.
- R3: On a `ufrm_start` that closes an IN microframe with N ≥ 2, fewer than N `bank_wr` pulses in that microframe set `in_underflow` in the following cycle. The flag then holds.
- R4: On the same boundary, fewer than N `trans_done` pulses set `flush_pending` and raise `flush_req` for exactly one cycle.
- R5: No boundary check is made when N = 1, for an OUT endpoint, or on the first `ufrm_start` after reset.
- R6: For OUT, each `trans_done` loads `pid_seq` with `rx_pid`.
- R7: The only legal OUT PID orders within a microframe are MDATA, MDATA, DATA2 (N = 3), MDATA, DATA1 (N = 2) and DATA0 (N = 1). Any other PID, or any packet beyond the N-th, sets `trans_err` in the following cycle.
- R8: `trans_err` stays high until software has released, with `bank_release`, all older queued banks and every bank of the bad microframe. It falls in the cycle after the last of those releases.
- R9: `pid_irq` pulses for one cycle after an OUT packet arrives. It needs `mdata_irq_en` for an MDATA packet and `datax_irq_en` for a DATA0, DATA1 or DATA2 packet. IN traffic never raises it.
- R10: `ack_underflow` and `ack_flush` clear their flag in the next cycle. A flag event at the same edge takes priority over the acknowledge.
- R11: Counting restarts at every `ufrm_start`, after the closing microframe has been checked. Pulses in the same cycle as `ufrm_start` count toward the new microframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| n_trans | input | 2 | Transactions per microframe (0 or 1 = one) |
| ufrm_start | input | 1 | Microframe start pulse |
| bank_wr | input | 1 | CPU handed over a filled IN bank |
| trans_done | input | 1 | Transaction completed (IN sent without underflow, or OUT received) |
| rx_pid | input | 2 | PID of the OUT packet flagged by trans_done |
| bank_release | input | 1 | Software released the current OUT bank |
| mdata_irq_en | input | 1 | Enable interrupt on MDATA reception |
| datax_irq_en | input | 1 | Enable interrupt on DATA0/1/2 reception |
| ack_underflow | input | 1 | Clear in_underflow |
| ack_flush | input | 1 | Clear flush_pending |
| in_underflow | output | 1 | Sticky: too few banks written |
| flush_pending | output | 1 | Sticky: too few transactions completed |
| flush_req | output | 1 | One-cycle request to empty the banks |
| trans_err | output | 1 | OUT sequence error tied to the bad microframe's banks |
| pid_seq | output | 2 | IN: next PID to send; OUT: last PID received |
| pid_irq | output | 1 | One-cycle PID reception interrupt |

## Verification
Each result is registered once. A stimulus applied before a clock edge shows on the outputs just after that edge, and `flush_req` and `pid_irq` fall again one edge later. The bench changes inputs 1 ns after a rising edge. It reads outputs 1 ns after the following rising edge, which is the first point where a response is due, and takes a second reading one cycle later wherever a pulse must have ended or a flag must have held. Within a microframe the bank and transaction pulses are spread over separate cycles, so each boundary result is read exactly one edge after its `ufrm_start`.

// File: rtl/hbiso_pkg.sv
package hbiso_pkg;

  typedef enum logic [1:0] {
    PID_DATA0 = 2'd0,
    PID_DATA1 = 2'd1,
    PID_DATA2 = 2'd2,
    PID_MDATA = 2'd3
  } pid_e;

  // width of the per-microframe counters
  localparam int IDX_W = 4;

  // configured count with 0 folded onto 1
  function automatic logic [1:0] eff_n(input logic [1:0] n);
    return (n == 2'd0) ? 2'd1 : n;
  endfunction

  function automatic logic is_hb(input logic [1:0] n);
    return eff_n(n) >= 2'd2;
  endfunction

  // PID of the first IN packet of a microframe
  function automatic pid_e in_first_pid(input logic [1:0] n);
    case (eff_n(n))
      2'd3:    return PID_DATA2;
      2'd2:    return PID_DATA1;
      default: return PID_DATA0;
    endcase
  endfunction

  // PID following p within an IN microframe, floored at DATA0
  function automatic pid_e in_step_pid(input pid_e p);
    return (p == PID_DATA2) ? PID_DATA1 : PID_DATA0;
  endfunction

  // legality of OUT packet number idx (0-based) carrying pid p
  function automatic logic out_pid_ok(input logic [1:0] n,
                                      input logic [IDX_W-1:0] idx,
                                      input pid_e p);
    logic [IDX_W-1:0] nn;
    nn = IDX_W'(eff_n(n));
    if (idx >= nn) return 1'b0;
    if (idx != nn - IDX_W'(1)) return p == PID_MDATA;
    case (nn)
      IDX_W'(3): return p == PID_DATA2;
      IDX_W'(2): return p == PID_DATA1;
      default:   return p == PID_DATA0;
    endcase
  endfunction

  function automatic logic shortfall(input logic [IDX_W-1:0] cnt,
                                     input logic [1:0] n);
    return cnt < IDX_W'(eff_n(n));
  endfunction

endpackage

// File: rtl/hbiso_ufrm_cnt.sv
module hbiso_ufrm_cnt
  import hbiso_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_in,
  input  logic [1:0]       n_trans,
  input  logic             ufrm_start,
  input  logic             bank_wr,
  input  logic             trans_done,
  output logic [IDX_W-1:0] out_idx,
  output logic             uf_evt,
  output logic             fl_evt
);

  logic             live_q;
  logic [IDX_W-1:0] bank_q;
  logic [IDX_W-1:0] done_q;
  logic             chk_w;

  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v,
                                               input logic en);
    return (en && (v != '1)) ? v + IDX_W'(1) : v;
  endfunction

  // boundary checks see the closing microframe's counts
  assign chk_w   = ufrm_start && live_q && is_in && is_hb(n_trans);
  assign uf_evt  = chk_w && shortfall(bank_q, n_trans);
  assign fl_evt  = chk_w && shortfall(done_q, n_trans);
  assign out_idx = ufrm_start ? '0 : done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      bank_q <= '0;
      done_q <= '0;
    end else if (ufrm_start) begin
      live_q <= 1'b1;
      bank_q <= IDX_W'(bank_wr);
      done_q <= IDX_W'(trans_done);
    end else begin
      bank_q <= sat_inc(bank_q, bank_wr);
      done_q <= sat_inc(done_q, trans_done);
    end
  end

endmodule

// File: rtl/hbiso_pid_track.sv
module hbiso_pid_track
  import hbiso_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_in,
  input  logic [1:0]       n_trans,
  input  logic             ufrm_start,
  input  logic             trans_done,
  input  pid_e             rx_pid,
  input  logic [IDX_W-1:0] out_idx,
  input  logic             mdata_irq_en,
  input  logic             datax_irq_en,
  output pid_e             pid_q,
  output logic             seq_err,
  output logic             pid_irq
);

  pid_e base_w;
  pid_e pid_n;
  logic out_rx_w;
  logic irq_d;

  assign out_rx_w = !is_in && trans_done;
  assign base_w   = ufrm_start ? in_first_pid(n_trans) : pid_q;
  assign seq_err  = out_rx_w && !out_pid_ok(n_trans, out_idx, rx_pid);
  assign irq_d    = out_rx_w &&
                    ((rx_pid == PID_MDATA) ? mdata_irq_en : datax_irq_en);

  always_comb begin
    if (is_in) pid_n = trans_done ? in_step_pid(base_w) : base_w;
    else       pid_n = trans_done ? rx_pid : pid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q   <= PID_DATA1;
      pid_irq <= 1'b0;
    end else begin
      pid_q   <= pid_n;
      pid_irq <= irq_d;
    end
  end

endmodule

// File: rtl/hbiso_err_hold.sv
module hbiso_err_hold
  import hbiso_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ufrm_start,
  input  logic             out_rx,
  input  logic             seq_err,
  input  logic             bank_release,
  input  logic [IDX_W-1:0] out_idx,
  output logic             err_flag
);

  logic [CNT_W-1:0] busy_q, skip_q, bad_q;
  logic [CNT_W-1:0] busy_a, skip_a, bad_a;
  logic [CNT_W-1:0] busy_n, skip_n, bad_n;
  logic [CNT_W-1:0] idx_c;
  logic             cur_q, cur_n, rel_ok;

  function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] v);
    return (v != '1) ? v + CNT_W'(1) : v;
  endfunction

  assign idx_c    = CNT_W'(out_idx);
  assign rel_ok   = bank_release && (busy_q != '0);
  assign err_flag = (skip_q != '0) || (bad_q != '0);

  always_comb begin
    // a release first retires older banks, then bad ones
    busy_a = busy_q - CNT_W'(rel_ok);
    skip_a = skip_q;
    bad_a  = bad_q;
    if (rel_ok) begin
      if (skip_q != '0)     skip_a = skip_q - CNT_W'(1);
      else if (bad_q != '0) bad_a  = bad_q - CNT_W'(1);
    end
    busy_n = out_rx ? inc_sat(busy_a) : busy_a;
    skip_n = skip_a;
    bad_n  = bad_a;
    cur_n  = cur_q && !ufrm_start;
    if (seq_err) begin
      if ((skip_a == '0) && (bad_a == '0)) begin
        if (busy_a >= idx_c) begin
          skip_n = busy_a - idx_c;
          bad_n  = idx_c + CNT_W'(1);
        end else begin
          skip_n = '0;
          bad_n  = busy_a + CNT_W'(1);
        end
      end else if (!cur_n) begin
        bad_n = busy_a + CNT_W'(1) - skip_a;
      end else begin
        bad_n = inc_sat(bad_a);
      end
      cur_n = 1'b1;
    end else if (out_rx && cur_n) begin
      bad_n = inc_sat(bad_a);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      skip_q <= '0;
      bad_q  <= '0;
      cur_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      skip_q <= skip_n;
      bad_q  <= bad_n;
      cur_q  <= cur_n;
    end
  end

endmodule

// File: rtl/hbiso_ufrm_chk.sv
module hbiso_ufrm_chk
  import hbiso_pkg::*;
#(
  parameter int MAX_BANKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_in,
  input  logic [1:0] n_trans,
  input  logic       ufrm_start,
  input  logic       bank_wr,
  input  logic       trans_done,
  input  logic [1:0] rx_pid,
  input  logic       bank_release,
  input  logic       mdata_irq_en,
  input  logic       datax_irq_en,
  input  logic       ack_underflow,
  input  logic       ack_flush,
  output logic       in_underflow,
  output logic       flush_pending,
  output logic       flush_req,
  output logic       trans_err,
  output logic [1:0] pid_seq,
  output logic       pid_irq
);

  localparam int CNT_W = $clog2(2 * MAX_BANKS + 2);
  localparam int NFLAG = 2;

  logic [IDX_W-1:0] out_idx_w;
  logic             uf_evt_w, fl_evt_w, seq_err_w;
  pid_e             pid_w;
  logic [NFLAG-1:0] set_v, ack_v, flag_q;
  logic             flush_req_q;

  hbiso_ufrm_cnt u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_in      (is_in),
    .n_trans    (n_trans),
    .ufrm_start (ufrm_start),
    .bank_wr    (bank_wr),
    .trans_done (trans_done),
    .out_idx    (out_idx_w),
    .uf_evt     (uf_evt_w),
    .fl_evt     (fl_evt_w)
  );

  hbiso_pid_track u_pid (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_in        (is_in),
    .n_trans      (n_trans),
    .ufrm_start   (ufrm_start),
    .trans_done   (trans_done),
    .rx_pid       (pid_e'(rx_pid)),
    .out_idx      (out_idx_w),
    .mdata_irq_en (mdata_irq_en),
    .datax_irq_en (datax_irq_en),
    .pid_q        (pid_w),
    .seq_err      (seq_err_w),
    .pid_irq      (pid_irq)
  );

  hbiso_err_hold #(.CNT_W(CNT_W)) u_err (
    .clk          (clk),
    .rst_n        (rst_n),
    .ufrm_start   (ufrm_start),
    .out_rx       (!is_in && trans_done),
    .seq_err      (seq_err_w),
    .bank_release (bank_release),
    .out_idx      (out_idx_w),
    .err_flag     (trans_err)
  );

  assign set_v = {fl_evt_w, uf_evt_w};
  assign ack_v = {ack_flush, ack_underflow};

  // sticky flags: an event outranks its acknowledge
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[g] <= 1'b0;
      else if (set_v[g]) flag_q[g] <= 1'b1;
      else if (ack_v[g]) flag_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flush_req_q <= 1'b0;
    else        flush_req_q <= fl_evt_w;
  end

  assign in_underflow  = flag_q[0];
  assign flush_pending = flag_q[1];
  assign flush_req     = flush_req_q;
  assign pid_seq       = pid_w;

endmodule

// File: rtl/hbiso_ufrm_chk_sva.sv
module hbiso_ufrm_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       is_in,
  input logic [1:0] n_trans,
  input logic       ufrm_start,
  input logic       trans_done,
  input logic       ack_underflow,
  input logic       uf_evt,
  input logic       seq_err,
  input logic       in_underflow,
  input logic       flush_pending,
  input logic       flush_req,
  input logic       trans_err,
  input logic [1:0] pid_seq,
  input logic       pid_irq
);

  AST_IN_FIRST_DATA2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_in && ufrm_start && !trans_done && n_trans == 2'd3) |=> (pid_seq == 2'd2)); // R2

  AST_UFLOW_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_underflow) |-> $past(ufrm_start)); // R3

  AST_FLUSH_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req); // R4

  AST_FLUSH_REQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> flush_pending); // R4

  AST_NO_CHECK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ufrm_start && n_trans < 2'd2 && !in_underflow && !flush_pending)
      |=> (!in_underflow && !flush_pending)); // R5

  AST_ERR_FOLLOWS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> trans_err); // R7

  AST_IRQ_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pid_irq |-> $past(trans_done && !is_in)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_underflow && !uf_evt) |=> !in_underflow); // R10

endmodule

bind hbiso_ufrm_chk hbiso_ufrm_chk_sva chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .is_in         (is_in),
  .n_trans       (n_trans),
  .ufrm_start    (ufrm_start),
  .trans_done    (trans_done),
  .ack_underflow (ack_underflow),
  .uf_evt        (uf_evt_w),
  .seq_err       (seq_err_w),
  .in_underflow  (in_underflow),
  .flush_pending (flush_pending),
  .flush_req     (flush_req),
  .trans_err     (trans_err),
  .pid_seq       (pid_seq),
  .pid_irq       (pid_irq)
);

// File: tb/hbiso_ufrm_chk_tb.sv
module hbiso_ufrm_chk_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_in = 1'b1;
  logic [1:0] n_trans = 2'd3;
  logic       ufrm_start = 1'b0, bank_wr = 1'b0, trans_done = 1'b0;
  logic [1:0] rx_pid = 2'd0;
  logic       bank_release = 1'b0, mdata_irq_en = 1'b0, datax_irq_en = 1'b0;
  logic       ack_underflow = 1'b0, ack_flush = 1'b0;
  logic       in_underflow, flush_pending, flush_req, trans_err, pid_irq;
  logic [1:0] pid_seq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hbiso_ufrm_chk dut_i (
    .clk(clk), .rst_n(rst_n), .is_in(is_in), .n_trans(n_trans),
    .ufrm_start(ufrm_start), .bank_wr(bank_wr), .trans_done(trans_done),
    .rx_pid(rx_pid), .bank_release(bank_release),
    .mdata_irq_en(mdata_irq_en), .datax_irq_en(datax_irq_en),
    .ack_underflow(ack_underflow), .ack_flush(ack_flush),
    .in_underflow(in_underflow), .flush_pending(flush_pending),
    .flush_req(flush_req), .trans_err(trans_err),
    .pid_seq(pid_seq), .pid_irq(pid_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    ufrm_start = 1'b1; tick(); ufrm_start = 1'b0;
  endtask

  task automatic in_txn(input bit wr, input bit dn);
    bank_wr = wr; trans_done = dn; tick(); bank_wr = 1'b0; trans_done = 1'b0;
  endtask

  task automatic out_rx(input logic [1:0] p);
    rx_pid = p; trans_done = 1'b1; tick(); trans_done = 1'b0;
  endtask

  task automatic rel();
    bank_release = 1'b1; tick(); bank_release = 1'b0;
  endtask

  task automatic ack_both();
    ack_underflow = 1'b1; ack_flush = 1'b1; tick();
    ack_underflow = 1'b0; ack_flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 underflow", in_underflow, 0);
    chk("R1 flush", flush_pending, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 trans_err", trans_err, 0);
    chk("R1 pid_irq", pid_irq, 0);
    chk("R1 pid_seq", pid_seq, 1);
  endtask

  task automatic t_in_full();
    is_in = 1'b1; n_trans = 2'd3;
    pulse_start();
    chk("R2 first pid n3", pid_seq, 2);
    chk("R5 first start no underflow", in_underflow, 0);
    chk("R5 first start no flush", flush_pending, 0);
    in_txn(1, 1); chk("R2 step 1", pid_seq, 1);
    in_txn(1, 1); chk("R2 step 2", pid_seq, 0);
    in_txn(1, 1); chk("R2 floor", pid_seq, 0);
    pulse_start();
    chk("R3 full no underflow", in_underflow, 0);
    chk("R4 full no flush", flush_pending, 0);
    chk("R4 full no req", flush_req, 0);
  endtask

  task automatic t_in_short();
    n_trans = 2'd2;
    in_txn(1, 1); in_txn(0, 1);
    pulse_start();
    chk("R3 one bank underflow", in_underflow, 1);
    chk("R4 two done no flush", flush_pending, 0);
    chk("R4 no req", flush_req, 0);
    chk("R2 first pid n2", pid_seq, 1);
    tick();
    chk("R3 underflow holds", in_underflow, 1);
    in_txn(1, 1); in_txn(1, 0);
    pulse_start();
    chk("R4 flush set", flush_pending, 1);
    chk("R4 req pulse", flush_req, 1);
    tick();
    chk("R4 req ends", flush_req, 0);
    ack_underflow = 1'b1; tick(); ack_underflow = 1'b0;
    chk("R10 ack clears underflow", in_underflow, 0);
    chk("R10 other flag kept", flush_pending, 1);
    ack_flush = 1'b1; ufrm_start = 1'b1; tick();
    ack_flush = 1'b0; ufrm_start = 1'b0;
    chk("R10 set beats ack", flush_pending, 1);
    chk("R3 empty frame underflow", in_underflow, 1);
    ack_both();
    chk("R10 both cleared uf", in_underflow, 0);
    chk("R10 both cleared fl", flush_pending, 0);
  endtask

  task automatic t_no_check();
    n_trans = 2'd1;
    pulse_start();
    chk("R5 n1 no underflow", in_underflow, 0);
    chk("R5 n1 no flush", flush_pending, 0);
    chk("R2 first pid n1", pid_seq, 0);
    is_in = 1'b0; n_trans = 2'd3;
    pulse_start();
    chk("R5 out no underflow", in_underflow, 0);
    chk("R5 out no req", flush_req, 0);
  endtask

  task automatic t_overlap();
    is_in = 1'b1; n_trans = 2'd2;
    pulse_start(); ack_both();
    in_txn(1, 1); in_txn(1, 1);
    ufrm_start = 1'b1; bank_wr = 1'b1; trans_done = 1'b1; tick();
    ufrm_start = 1'b0; bank_wr = 1'b0; trans_done = 1'b0;
    chk("R11 full frame clean", in_underflow, 0);
    chk("R11 pid after start+done", pid_seq, 0);
    in_txn(1, 1);
    pulse_start();
    chk("R11 overlap counted uf", in_underflow, 0);
    chk("R11 overlap counted fl", flush_pending, 0);
  endtask

  task automatic t_out_good();
    is_in = 1'b0; n_trans = 2'd3; mdata_irq_en = 1'b1; datax_irq_en = 1'b1;
    pulse_start();
    out_rx(2'd3);
    chk("R9 mdata irq", pid_irq, 1);
    chk("R6 pid mdata", pid_seq, 3);
    tick();
    chk("R9 irq one cycle", pid_irq, 0);
    out_rx(2'd3);
    datax_irq_en = 1'b0;
    out_rx(2'd2);
    chk("R9 datax disabled", pid_irq, 0);
    chk("R6 pid data2", pid_seq, 2);
    chk("R7 legal n3 order", trans_err, 0);
    rel(); rel(); rel();
    chk("R8 no error after releases", trans_err, 0);
  endtask

  task automatic t_out_bad();
    n_trans = 2'd2; datax_irq_en = 1'b1; mdata_irq_en = 1'b0;
    pulse_start();
    out_rx(2'd3);
    chk("R9 mdata disabled", pid_irq, 0);
    out_rx(2'd1);
    chk("R9 data1 irq", pid_irq, 1);
    chk("R7 legal n2 order", trans_err, 0);
    pulse_start();
    out_rx(2'd3);
    chk("R7 first mdata ok", trans_err, 0);
    out_rx(2'd3);
    chk("R7 mdata twice n2", trans_err, 1);
    pulse_start();
    out_rx(2'd3); out_rx(2'd1);
    chk("R8 holds next frame", trans_err, 1);
    rel(); chk("R8 older bank 1", trans_err, 1);
    rel(); chk("R8 older bank 2", trans_err, 1);
    rel(); chk("R8 bad bank 1", trans_err, 1);
    rel(); chk("R8 clears after bad banks", trans_err, 0);
    rel(); rel(); chk("R8 stays clear", trans_err, 0);
    n_trans = 2'd1;
    pulse_start();
    out_rx(2'd1);
    chk("R7 n1 needs data0", trans_err, 1);
    rel(); chk("R8 single bad released", trans_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_in_full();
    t_in_short();
    t_no_check();
    t_overlap();
    t_out_good();
    t_out_bad();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule